// File: doc/BRIEF.md
# Byte-Sequential Result Strobe Interface

This block sits between a conversion engine and an 8-bit consumer. It takes a 16-bit result word and its clip flag and sends them as two bytes framed by one strobe pulse. The first byte is on the bus when the strobe rises and the second byte is on the bus when the strobe falls. A select input picks the byte order when the result is captured. After the strobe falls the same input works as a read mux over the held result, so a consumer can poll either byte at its own pace.

The block also gates convert commands. Only a rising edge on the convert input starts a conversion, and only when no conversion is in flight. An edge that arrives before the previous strobe has fallen is dropped, not queued. As an option, the block derives latched overrange and underrange flags from the clip flag and the data bits. Setup and strobe timing are counted in system clock cycles, and all outputs are registered.

Top module: `byte_seq_out`

## Requirements
- R1: After reset, a 0-to-1 transition of `conv_in` seen while idle is accepted. One clock later `start_o` pulses for exactly one cycle and `busy_o` rises in the same cycle.
- R2: A convert edge seen while `busy_o` is high is dropped. This includes a level that is still high when the block goes idle. No `start_o` follows, and `busy_o` stays low afterwards.
- R3: `busy_o` stays high from the accepted edge until the strobe falls, and it drops on the same clock edge as `stb_o`.
- R4: Once per accepted conversion, `stb_o` is high for exactly `HIGH_CYC` consecutive cycles.
- R5: The first byte is driven `SETUP_CYC` cycles before `stb_o` rises, starting the cycle after the `rdy_in` pulse. `sel_in`=0 at `rdy_in` sends the high byte (`res_in[15:8]`) first. `sel_in`=1 sends the low byte (`res_in[7:0]`) first. Later changes of `sel_in` do not alter the order.
- R6: The second byte replaces the first `HOLD_CYC` cycles after `stb_o` rises and stays until the strobe has fallen. `HIGH_CYC` must be at least `HOLD_CYC + SETUP_CYC`.
- R7: `clip_o` equals the captured clip flag while the high byte is on the bus, and is 0 while the low byte is on the bus.
- R8: Polled mode applies from the cycle after the strobe falls until the next `rdy_in` pulse, including while a new conversion is busy. The bus shows the held high byte when `sel_in`=0 and the held low byte when `sel_in`=1, one cycle after `sel_in` is sampled.
- R9: A `rdy_in` pulse is ignored unless a conversion has been accepted and its strobe sequence has not begun. The held result and the bus are unchanged.
- R10: With `EN_RANGE`=1, `ovr_o` is set to (clip & all 16 bits 1) and `udr_o` to (clip & all 16 bits 0). Both update on the strobe edge that carries the high byte: the rising edge for high-first order and the falling edge for low-first order. Both hold until the next such edge.
- R11: Synchronous reset clears `bus_o`, `clip_o`, `stb_o`, `busy_o`, `start_o`, `ovr_o`, `udr_o` and the held result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_in | input | 1 | Convert command level; its rising edge requests a conversion |
| rdy_in | input | 1 | One-cycle pulse from the engine: result is valid |
| res_in | input | 16 | Conversion result, bit 15 is the MSB |
| clip_in | input | 1 | Clip flag accompanying the result |
| sel_in | input | 1 | Byte order at capture, byte pick in polled mode |
| start_o | output | 1 | One-cycle pulse telling the engine to start |
| busy_o | output | 1 | Conversion in flight until the strobe falls |
| stb_o | output | 1 | Data strobe framing both bytes |
| bus_o | output | 8 | Byte-wide result bus |
| clip_o | output | 1 | Clip flag, qualified by the high byte being shown |
| ovr_o | output | 1 | Latched overrange flag |
| udr_o | output | 1 | Latched underrange flag |

## Verification
The bench aims convert edges into the busy window, up to the last cycle of the strobe, and holds the convert level high across the point where the block goes idle. A gate that queues requests, or that treats a held level as a new edge, would emit a spurious start. It toggles the select input in the middle of a sequence and pulses ready during the strobe and while idle. A design that re-samples the order or re-captures the result would then show the wrong byte. All-ones and all-zeros words are sent with and without clip in both byte orders, because latching the range flags on the wrong strobe edge shows up as a one-phase skew against the expected flag timeline.

// File: rtl/bso_pkg.sv
package bso_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_HI
  } bso_st_e;
endpackage

// File: rtl/bso_conv_gate.sv
module bso_conv_gate (
  input  logic clk,
  input  logic rst,
  input  logic conv_in,
  input  logic idle_i,
  output logic acc_o,
  output logic start_o
);
  logic conv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      conv_q  <= conv_in;
      start_o <= acc_o;
    end
  end

  assign acc_o = conv_in & ~conv_q & idle_i;

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/bso_seq.sv
module bso_seq #(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int HIGH_CYC  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] res_i,
  input  logic          clip_i,
  input  logic          sel_i,
  output logic [DW/2-1:0] bus_o,
  output logic          clip_o,
  output logic          stb_o,
  output logic          busy_o,
  output logic          idle_o,
  output logic          hb_edge_o,
  output logic [DW-1:0] word_o,
  output logic          wclip_o
);
  import bso_pkg::*;

  localparam int BW   = DW / 2;
  localparam int MAXC = (HIGH_CYC > SETUP_CYC) ? HIGH_CYC : SETUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_END  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CYC - 1);

  bso_st_e       st;
  logic [CW-1:0] cnt;
  logic          lofirst;
  logic [BW-1:0] poll_byte;
  logic          poll_clip;

  assign poll_byte = sel_i ? word_o[BW-1:0] : word_o[DW-1:BW];
  assign poll_clip = ~sel_i & wclip_o;
  assign idle_o    = (st == ST_IDLE);
  assign hb_edge_o = ((st == ST_PRE) && (cnt == SET_END)  && !lofirst) ||
                     ((st == ST_HI)  && (cnt == HIGH_END) &&  lofirst);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      lofirst <= 1'b0;
      word_o  <= '0;
      wclip_o <= 1'b0;
      bus_o   <= '0;
      clip_o  <= 1'b0;
      stb_o   <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          bus_o  <= poll_byte;
          clip_o <= poll_clip;
          if (acc_i) begin
            st     <= ST_WAIT;
            busy_o <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (rdy_i) begin
            word_o  <= res_i;
            wclip_o <= clip_i;
            lofirst <= sel_i;
            bus_o   <= sel_i ? res_i[BW-1:0] : res_i[DW-1:BW];
            clip_o  <= ~sel_i & clip_i;
            cnt     <= '0;
            st      <= ST_PRE;
          end else begin
            bus_o  <= poll_byte;
            clip_o <= poll_clip;
          end
        end
        ST_PRE: begin
          if (cnt == SET_END) begin
            stb_o <= 1'b1;
            cnt   <= '0;
            st    <= ST_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HI: begin
          cnt <= cnt + 1'b1;
          if (cnt == HOLD_END) begin
            bus_o  <= lofirst ? word_o[DW-1:BW] : word_o[BW-1:0];
            clip_o <= lofirst & wclip_o;
          end
          if (cnt == HIGH_END) begin
            stb_o  <= 1'b0;
            busy_o <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  stb_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> busy_o);
  // R3
  fall_frees_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stb_o) |-> !busy_o);
  // R4
  stb_width_chk: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> (cnt < CW'(HIGH_CYC)));
  // R6
  fall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stb_o) |-> $stable(bus_o));
  // R9
  idle_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !stb_o);
endmodule

// File: rtl/bso_range.sv
module bso_range #(
  parameter int DW       = 16,
  parameter bit EN_RANGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  logic [DW-1:0] word_i,
  input  logic          clip_i,
  output logic          ovr_o,
  output logic          udr_o
);
  generate
    if (EN_RANGE) begin : g_range
      always_ff @(posedge clk) begin
        if (rst) begin
          ovr_o <= 1'b0;
          udr_o <= 1'b0;
        end else if (upd_i) begin
          ovr_o <= clip_i & (&word_i);
          udr_o <= clip_i & ~(|word_i);
        end
      end

      // R10
      range_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovr_o && udr_o));
      // R10
      range_upd_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_o != $past(ovr_o)) |-> $past(upd_i));
    end else begin : g_norange
      assign ovr_o = 1'b0;
      assign udr_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/byte_seq_out.sv
module byte_seq_out #(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int HIGH_CYC  = 5,
  parameter bit EN_RANGE  = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_in,
  input  logic            rdy_in,
  input  logic [DW-1:0]   res_in,
  input  logic            clip_in,
  input  logic            sel_in,
  output logic            start_o,
  output logic            busy_o,
  output logic            stb_o,
  output logic [DW/2-1:0] bus_o,
  output logic            clip_o,
  output logic            ovr_o,
  output logic            udr_o
);
  logic          acc;
  logic          idle;
  logic          hb_edge;
  logic [DW-1:0] word;
  logic          wclip;

  bso_conv_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .conv_in (conv_in),
    .idle_i  (idle),
    .acc_o   (acc),
    .start_o (start_o)
  );

  bso_seq #(
    .DW        (DW),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .HIGH_CYC  (HIGH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .acc_i     (acc),
    .rdy_i     (rdy_in),
    .res_i     (res_in),
    .clip_i    (clip_in),
    .sel_i     (sel_in),
    .bus_o     (bus_o),
    .clip_o    (clip_o),
    .stb_o     (stb_o),
    .busy_o    (busy_o),
    .idle_o    (idle),
    .hb_edge_o (hb_edge),
    .word_o    (word),
    .wclip_o   (wclip)
  );

  bso_range #(
    .DW       (DW),
    .EN_RANGE (EN_RANGE)
  ) u_range (
    .clk    (clk),
    .rst    (rst),
    .upd_i  (hb_edge),
    .word_i (word),
    .clip_i (wclip),
    .ovr_o  (ovr_o),
    .udr_o  (udr_o)
  );

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> start_o);
endmodule

// File: tb/byte_seq_out_bench.sv
module byte_seq_out_bench;
  localparam int SETUP = 2;
  localparam int HOLD  = 2;
  localparam int HIGH  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_in = 1'b0;
  logic        rdy_in = 1'b0;
  logic [15:0] res_in = '0;
  logic        clip_in = 1'b0;
  logic        sel_in = 1'b0;
  logic        start_o, busy_o, stb_o, clip_o, ovr_o, udr_o;
  logic [7:0]  bus_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [15:0] held_w = '0;
  logic        held_c = 1'b0;
  logic        exp_ovr = 1'b0;
  logic        exp_udr = 1'b0;

  always #2 clk = ~clk;

  byte_seq_out u_byte_seq_out (
    .clk(clk), .rst(rst), .conv_in(conv_in), .rdy_in(rdy_in),
    .res_in(res_in), .clip_in(clip_in), .sel_in(sel_in),
    .start_o(start_o), .busy_o(busy_o), .stb_o(stb_o), .bus_o(bus_o),
    .clip_o(clip_o), .ovr_o(ovr_o), .udr_o(udr_o)
  );

  function automatic logic [7:0] pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  // R8: polled reads of the held result, one cycle latency
  task automatic poll(input int n);
    for (int k = 0; k < n; k++) begin
      sel_in = 1'($urandom);
      @(negedge clk);
      chk("R8 poll bus", bus_o, pick(held_w, !sel_in));
      chk("R7 poll clip", clip_o, held_c & !sel_in);
    end
  endtask

  task automatic do_conv(input logic [15:0] w, input logic c, input logic s,
                         input int early_at, input bit hold_conv);
    int last;
    logic n_ovr, n_udr;
    last = SETUP + HIGH;
    n_ovr = c & (&w);
    n_udr = c & ~(|w);
    conv_in = 1'b1;
    @(negedge clk);
    chk("R1 start", start_o, 1);
    chk("R1 busy", busy_o, 1);
    conv_in = 1'b0;
    poll(2);
    chk("R1 start one cycle", start_o, 0);
    rdy_in = 1'b1; res_in = w; clip_in = c; sel_in = s;
    @(negedge clk);
    rdy_in = 1'b0; res_in = ~w; clip_in = ~c;
    sel_in = 1'($urandom);
    for (int i = 0; i <= last; i++) begin
      logic hib;
      logic [7:0] eb;
      if (i < SETUP + HOLD) hib = !s; else hib = s;
      eb = pick(w, hib);
      chk("R5/R6 bus", bus_o, eb);
      chk("R7 clip", clip_o, hib & c);
      chk("R4 strobe", stb_o, (i >= SETUP) && (i < last));
      chk("R3 busy", busy_o, i < last);
      if (i == (s ? last : SETUP)) begin
        exp_ovr = n_ovr;
        exp_udr = n_udr;
      end
      chk("R10 ovr", ovr_o, exp_ovr);
      chk("R10 udr", udr_o, exp_udr);
      if (i > 0) chk("R2 no start", start_o, 0);
      sel_in = 1'($urandom);
      rdy_in = (i == SETUP + 1);
      if (i == early_at) conv_in = 1'b1;
      else if (!hold_conv) conv_in = 1'b0;
      @(negedge clk);
    end
    rdy_in = 1'b0;
    chk("R2 dropped edge start", start_o, 0);
    chk("R2 dropped edge busy", busy_o, 0);
    conv_in = 1'b0;
    held_w = w;
    held_c = c;
    poll(3);
  endtask

  initial begin
    void'($urandom(32'h5eed_0b5e));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 bus", bus_o, 0);
    chk("R11 strobe", stb_o, 0);
    chk("R11 busy", busy_o, 0);
    chk("R11 start", start_o, 0);
    chk("R11 clip", clip_o, 0);
    chk("R11 ovr", ovr_o, 0);
    chk("R11 udr", udr_o, 0);

    // directed: both orders, range corners
    do_conv(16'hA55A, 1'b0, 1'b0, -1, 1'b0);
    do_conv(16'h1234, 1'b1, 1'b1, -1, 1'b0);
    do_conv(16'hFFFF, 1'b1, 1'b0, 3, 1'b0);
    do_conv(16'h0000, 1'b1, 1'b1, SETUP + HIGH - 1, 1'b0);
    do_conv(16'hFFFF, 1'b0, 1'b1, 0, 1'b1);
    do_conv(16'h0000, 1'b1, 1'b0, SETUP + HIGH - 1, 1'b1);
    do_conv(16'hFFFF, 1'b1, 1'b1, -1, 1'b0);

    // R9: ready pulse while idle must not disturb the held result
    rdy_in = 1'b1; res_in = ~held_w; clip_in = ~held_c;
    @(negedge clk);
    rdy_in = 1'b0;
    poll(4);

    // random mix
    for (int r = 0; r < 40; r++) begin
      logic [15:0] w;
      int ea;
      w = 16'($urandom);
      if (($urandom % 4) == 0) w = ($urandom % 2) ? 16'hFFFF : 16'h0000;
      ea = int'($urandom % (SETUP + HIGH + 1)) - 1;
      do_conv(w, 1'($urandom), 1'($urandom), ea, 1'($urandom));
    end
    summary();
  end
endmodule